// File: doc/BRIEF.md
# Prefetch and ECC Register Bank

This block holds the software-visible control state for a read-prefetch engine and for a bank of nine parity accumulators used for error correction on a byte-wide flash device. It sits on a simple single-cycle register bus. Register writes take effect on the next clock edge. Read data is registered and appears one cycle after the read strobe.

On the prefetch side, the bank keeps two masked configuration words and a run bit. Writing the run bit as 1 pre-loads the FIFO level: the level becomes full when the direction bit of the first configuration word is set, and empty when it is clear. A read-only status word is assembled from three parts: the current FIFO level, a comparison of that level against a threshold field, and a transfer count supplied by the data path.

On the correction side, the bank keeps an enable/configuration nibble, a slot pointer and a size-configuration word. The pointer checks its own range: an out-of-range value resets it and turns correction off. The same control write can also issue a one-cycle clear pulse to every accumulator. Each accumulator delivers column and line parity, and the bank packs these into a read-only 32-bit result word for that slot.

Top module: `pfecc_regs`

## Requirements
- R1: After reset, reads return 0x00004000 at prefetch config A (0x00), 0 at prefetch config B (0x04), run control (0x08), correction config (0x10) and pointer (0x14), and 0x3FCFF000 at size config (0x18). `fifo_level`, `ecc_ptr`, `ecc_enable` and `prefetch_run` are 0. Read data appears on `rdata` one cycle after `rd_en`.
- R2: Written values are stored masked. Config A keeps 0x7F8F7FBF, config B keeps 0x3FFF, size config keeps 0x3FCFF1FF, correction config keeps 0xF, and run control keeps bit 0 only.
- R3: A run-control write with bit 0 = 1 sets the FIFO level to 64 if config A bit 0 is 1, and to 0 otherwise. A run-control write with bit 0 = 0 leaves the level unchanged.
- R4: The status word at 0x0C has the FIFO level in bits 31:24 and `xfer_count` in bits 13:0. Bit 16 is 1 exactly when the level is greater than config A bits 14:8. All other bits are 0.
- R5: A write to the pointer register (0x14) with bit 8 set raises `acc_clear` during that write cycle only. No other write raises it.
- R6: A pointer write stores bits 3:0 when the value is 1 to 9. For 0 or for 10 to 15, the pointer becomes 0 and correction config bit 0 (`ecc_enable`) is cleared, while its bits 3:1 are kept.
- R7: The result word for a slot places column parity bits 2:0 at 2:0, column parity bits 5:3 at 18:16, line parity A bits 8:0 at 11:3 and line parity B bits 8:0 at 27:19. All other bits are 0.
- R8: Result words lie at 0x40 to 0x60, and the slot is selected by address bits 4:2, so 0x60 reads slot 0. Writes to the result range and to the status word change nothing.
- R9: Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| xfer_count | input | 14 | Transfer count from the prefetch data path |
| col_par | input | 54 | Column parity, 6 bits per slot, slot 0 in the low bits |
| line_par_a | input | 81 | Line parity A, 9 bits per slot |
| line_par_b | input | 81 | Line parity B, 9 bits per slot |
| acc_clear | output | 1 | One-cycle clear to all accumulators |
| ecc_ptr | output | 4 | Current accumulator pointer |
| ecc_enable | output | 1 | Correction config bit 0 |
| fifo_level | output | 8 | Prefetch FIFO level |
| prefetch_run | output | 1 | Run control bit |

## Verification
The assertions assume that `wr_en` and `rd_en` are never both high and that bus inputs do not change between edges. The bench drives every access from the falling edge and issues one access per cycle. The FIFO-level properties assume that only a run-control write can move the level, so the bench never relies on the level changing in any other way. The parity inputs are taken as static, so the bench sets them before reset and does not change them while reading results.

// File: rtl/pfecc_pkg.sv
package pfecc_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 14;

  localparam logic [ADDR_W-1:0] OFS_PF_CFGA   = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_PF_CFGB   = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_PF_RUN    = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_PF_STAT   = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_ECC_CFG   = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_ECC_PTR   = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_ECC_SIZE  = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_RES_LO    = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_RES_HI    = 8'h60;

  localparam logic [DATA_W-1:0] MSK_PF_CFGA   = 32'h7F8F_7FBF;
  localparam logic [DATA_W-1:0] MSK_PF_CFGB   = 32'h0000_3FFF;
  localparam logic [DATA_W-1:0] MSK_ECC_SIZE  = 32'h3FCF_F1FF;
  localparam logic [DATA_W-1:0] RST_PF_CFGA   = 32'h0000_4000;
  localparam logic [DATA_W-1:0] RST_ECC_SIZE  = 32'h3FCF_F000;

  localparam int CLR_BIT = 8;
endpackage

// File: rtl/pf_regs.sv
module pf_regs
  import pfecc_pkg::*;
#(
  parameter int FIFO_W     = 8,
  parameter int FULL_LEVEL = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  xfer_count,
  output logic [DATA_W-1:0] cfg_a,
  output logic [DATA_W-1:0] cfg_b,
  output logic              run_q,
  output logic [FIFO_W-1:0] level_q,
  output logic [DATA_W-1:0] status
);
  localparam logic [FIFO_W-1:0] FULL = FIFO_W'(FULL_LEVEL);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_a   <= RST_PF_CFGA;
      cfg_b   <= '0;
      run_q   <= 1'b0;
      level_q <= '0;
    end else if (wr_en) begin
      case (addr)
        OFS_PF_CFGA: cfg_a <= wdata & MSK_PF_CFGA;
        OFS_PF_CFGB: cfg_b <= wdata & MSK_PF_CFGB;
        OFS_PF_RUN: begin
          run_q <= wdata[0];
          if (wdata[0]) level_q <= cfg_a[0] ? FULL : '0;
        end
        default: ;
      endcase
    end
  end

  logic [FIFO_W-1:0] thresh;
  logic              above;
  assign thresh = FIFO_W'(cfg_a[14:8]);
  assign above  = level_q > thresh;

  always_comb begin
    status = '0;
    status[24 +: FIFO_W] = level_q;
    status[16]           = above;
    status[CNT_W-1:0]    = xfer_count;
  end
endmodule

// File: rtl/ecc_regs.sv
module ecc_regs
  import pfecc_pkg::*;
#(
  parameter int SLOTS = 9,
  localparam int PTR_W = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [3:0]        cfg_q,
  output logic [PTR_W-1:0]  ptr_q,
  output logic [DATA_W-1:0] size_q,
  output logic              clr_pulse
);
  localparam logic [PTR_W-1:0] MAX_PTR = PTR_W'(SLOTS);

  logic [PTR_W-1:0] new_ptr;
  logic             ptr_bad;
  logic             ptr_wr;
  assign ptr_wr    = wr_en && (addr == OFS_ECC_PTR);
  assign new_ptr   = wdata[PTR_W-1:0];
  assign ptr_bad   = (new_ptr == '0) || (new_ptr > MAX_PTR);
  assign clr_pulse = ptr_wr && wdata[CLR_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      ptr_q  <= '0;
      size_q <= RST_ECC_SIZE;
    end else if (wr_en) begin
      case (addr)
        OFS_ECC_CFG:  cfg_q  <= wdata[3:0];
        OFS_ECC_SIZE: size_q <= wdata & MSK_ECC_SIZE;
        OFS_ECC_PTR: begin
          if (ptr_bad) begin
            ptr_q    <= '0;
            cfg_q[0] <= 1'b0;
          end else begin
            ptr_q <= new_ptr;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ecc_pack.sv
module ecc_pack
  import pfecc_pkg::*;
#(
  parameter int SLOTS = 9,
  parameter int CP_W  = 6,
  parameter int LP_W  = 9,
  localparam int HALF = CP_W / 2
) (
  input  logic [SLOTS*CP_W-1:0]             col_par,
  input  logic [SLOTS*LP_W-1:0]             lpar_a,
  input  logic [SLOTS*LP_W-1:0]             lpar_b,
  output logic [SLOTS-1:0][DATA_W-1:0]      words
);
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [CP_W-1:0] cp;
    assign cp = col_par[s*CP_W +: CP_W];
    always_comb begin
      words[s] = '0;
      words[s][HALF-1:0]        = cp[HALF-1:0];
      words[s][16 +: HALF]      = cp[CP_W-1:HALF];
      words[s][HALF +: LP_W]    = lpar_a[s*LP_W +: LP_W];
      words[s][16+HALF +: LP_W] = lpar_b[s*LP_W +: LP_W];
    end
  end
endmodule

// File: rtl/pfecc_regs.sv
module pfecc_regs
  import pfecc_pkg::*;
#(
  parameter int SLOTS      = 9,
  parameter int CP_W       = 6,
  parameter int LP_W       = 9,
  parameter int FIFO_W     = 8,
  parameter int FULL_LEVEL = 64,
  localparam int PTR_W     = $clog2(SLOTS + 1),
  localparam int IDX_W     = $clog2(SLOTS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W-1:0]      wdata,
  output logic [DATA_W-1:0]      rdata,
  input  logic [CNT_W-1:0]       xfer_count,
  input  logic [SLOTS*CP_W-1:0]  col_par,
  input  logic [SLOTS*LP_W-1:0]  line_par_a,
  input  logic [SLOTS*LP_W-1:0]  line_par_b,
  output logic                   acc_clear,
  output logic [PTR_W-1:0]       ecc_ptr,
  output logic                   ecc_enable,
  output logic [FIFO_W-1:0]      fifo_level,
  output logic                   prefetch_run
);
  logic [DATA_W-1:0] cfg_a, cfg_b, status, size_q;
  logic [3:0]        ecc_cfg;
  logic [SLOTS-1:0][DATA_W-1:0] words;

  pf_regs #(.FIFO_W(FIFO_W), .FULL_LEVEL(FULL_LEVEL)) u_pf (
    .clk, .rst, .wr_en, .addr, .wdata, .xfer_count,
    .cfg_a, .cfg_b, .run_q(prefetch_run), .level_q(fifo_level), .status
  );

  ecc_regs #(.SLOTS(SLOTS)) u_ecc (
    .clk, .rst, .wr_en, .addr, .wdata,
    .cfg_q(ecc_cfg), .ptr_q(ecc_ptr), .size_q, .clr_pulse(acc_clear)
  );

  ecc_pack #(.SLOTS(SLOTS), .CP_W(CP_W), .LP_W(LP_W)) u_pack (
    .col_par, .lpar_a(line_par_a), .lpar_b(line_par_b), .words
  );

  assign ecc_enable = ecc_cfg[0];

  logic              in_res;
  logic [2:0]        slot_sel;
  logic [IDX_W-1:0]  res_idx;
  logic [DATA_W-1:0] rd_mux;
  assign in_res   = (addr >= OFS_RES_LO) && (addr <= OFS_RES_HI) && (addr[1:0] == 2'b00);
  assign slot_sel = addr[4:2];
  assign res_idx  = IDX_W'(slot_sel);

  always_comb begin
    case (addr)
      OFS_PF_CFGA:  rd_mux = cfg_a;
      OFS_PF_CFGB:  rd_mux = cfg_b;
      OFS_PF_RUN:   rd_mux = DATA_W'(prefetch_run);
      OFS_PF_STAT:  rd_mux = status;
      OFS_ECC_CFG:  rd_mux = DATA_W'(ecc_cfg);
      OFS_ECC_PTR:  rd_mux = DATA_W'(ecc_ptr);
      OFS_ECC_SIZE: rd_mux = size_q;
      default:      rd_mux = (in_res && (32'(slot_sel) < SLOTS)) ? words[res_idx] : '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/pfecc_regs_chk.sv
module pfecc_regs_chk
  import pfecc_pkg::*;
#(
  parameter int SLOTS      = 9,
  parameter int FIFO_W     = 8,
  parameter int FULL_LEVEL = 64,
  localparam int PTR_W     = $clog2(SLOTS + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              acc_clear,
  input logic [PTR_W-1:0]  ecc_ptr,
  input logic              ecc_enable,
  input logic [FIFO_W-1:0] fifo_level
);
  logic ptr_wr, ptr_bad, run_wr;
  assign ptr_wr  = wr_en && (addr == OFS_ECC_PTR);
  assign ptr_bad = (wdata[PTR_W-1:0] == '0) || (32'(wdata[PTR_W-1:0]) > SLOTS);
  assign run_wr  = wr_en && (addr == OFS_PF_RUN) && wdata[0];

  a_r5_clear_only_on_ptr_write: assert property (@(posedge clk) disable iff (rst)
    acc_clear |-> ptr_wr);

  a_r6_ptr_in_range: assert property (@(posedge clk) disable iff (rst)
    32'(ecc_ptr) <= SLOTS);

  a_r6_bad_ptr_disables: assert property (@(posedge clk) disable iff (rst)
    (ptr_wr && ptr_bad) |=> (ecc_ptr == '0) && !ecc_enable);

  a_r6_good_ptr_stored: assert property (@(posedge clk) disable iff (rst)
    (ptr_wr && !ptr_bad) |=> ecc_ptr == $past(wdata[PTR_W-1:0]));

  a_r3_level_hold: assert property (@(posedge clk) disable iff (rst)
    !run_wr |=> $stable(fifo_level));

  a_r3_level_values: assert property (@(posedge clk) disable iff (rst)
    (fifo_level == '0) || (32'(fifo_level) == FULL_LEVEL));
endmodule

bind pfecc_regs pfecc_regs_chk #(.SLOTS(SLOTS), .FIFO_W(FIFO_W), .FULL_LEVEL(FULL_LEVEL)) u_chk (
  .clk, .rst, .wr_en, .addr, .wdata, .acc_clear, .ecc_ptr, .ecc_enable, .fifo_level
);

// File: tb/pfecc_regs_bench.sv
module pfecc_regs_bench;
  localparam int SLOTS = 9;
  localparam int CP_W  = 6;
  localparam int LP_W  = 9;

  logic clk = 0;
  logic rst = 1;
  logic wr_en = 0, rd_en = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic [13:0] xfer_count = 0;
  logic [SLOTS*CP_W-1:0] col_par = '0;
  logic [SLOTS*LP_W-1:0] line_par_a = '0, line_par_b = '0;
  logic acc_clear, ecc_enable, prefetch_run;
  logic [3:0] ecc_ptr;
  logic [7:0] fifo_level;

  int n_run = 0, n_fail = 0;
  bit finished = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  pfecc_regs u_pfecc_regs (
    .clk, .rst, .wr_en, .rd_en, .addr, .wdata, .rdata, .xfer_count,
    .col_par, .line_par_a, .line_par_b, .acc_clear, .ecc_ptr,
    .ecc_enable, .fifo_level, .prefetch_run
  );

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wr_clr(input logic [7:0] a, input logic [31:0] d, input logic exp_clr, input string tag);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    #1 check(32'(acc_clear), 32'(exp_clr), tag);
    @(negedge clk);
    wr_en = 0;
    #1 check(32'(acc_clear), 32'd0, {tag, " after"});
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    rd_en = 1; addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 0;
  endtask

  // monitor: rdata is registered on the edge that samples rd_en
  always @(posedge clk) begin
    if (!rst && rd_en) begin
      #5;
      if (exp_q.size() == 0) check(rdata, 32'hx, "scoreboard underflow");
      else check(rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  function automatic logic [31:0] pack_word(input int s);
    logic [5:0] cp = col_par[s*CP_W +: CP_W];
    logic [8:0] la = line_par_a[s*LP_W +: LP_W];
    logic [8:0] lb = line_par_b[s*LP_W +: LP_W];
    return {4'b0, lb, cp[5:3], 4'b0, la, cp[2:0]};
  endfunction

  initial begin
    #(20 * 20000);
    if (!finished) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < SLOTS; s++) begin
      col_par[s*CP_W +: CP_W]    = 6'(s * 7 + 5);
      line_par_a[s*LP_W +: LP_W] = 9'(s * 37 + 100);
      line_par_b[s*LP_W +: LP_W] = 9'(s * 53 + 3);
    end
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check(rdata, 0, "R1 rdata reset");
    check(32'(fifo_level), 0, "R1 fifo reset");
    check(32'(ecc_ptr), 0, "R1 ptr reset");
    check(32'({ecc_enable, prefetch_run}), 0, "R1 enable/run reset");
    rd(8'h00, 32'h0000_4000, "R1 cfgA reset");
    rd(8'h04, 0, "R1 cfgB reset");
    rd(8'h08, 0, "R1 run reset");
    rd(8'h10, 0, "R1 ecc cfg reset");
    rd(8'h14, 0, "R1 ptr reg reset");
    rd(8'h18, 32'h3FCF_F000, "R1 size reset");
    rd(8'h1C, 0, "R9 unmapped 0x1C");
    rd(8'hF0, 0, "R9 unmapped 0xF0");
    // R2 masks
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, 32'h7F8F_7FBF, "R2 cfgA mask");
    wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, 32'h0000_3FFF, "R2 cfgB mask");
    wr(8'h18, 32'hFFFF_FFFF); rd(8'h18, 32'h3FCF_F1FF, "R2 size mask");
    wr(8'h10, 32'hFFFF_FFF0); rd(8'h10, 0, "R2 ecc cfg mask");
    wr(8'h08, 32'hFFFF_FFFE); rd(8'h08, 0, "R2 run mask");
    check(32'(fifo_level), 0, "R3 run=0 keeps level");
    // R3/R4 start with direction bit set
    xfer_count = 14'h1234;
    wr(8'h08, 32'h1);
    check(32'(fifo_level), 32'h40, "R3 start full");
    check(32'(prefetch_run), 1, "R2 run bit");
    rd(8'h0C, 32'h4000_1234, "R4 status below threshold 0x7F");
    wr(8'h00, 32'h0000_3001);
    rd(8'h0C, 32'h4001_1234, "R4 status above threshold 0x30");
    wr(8'h00, 32'h0000_4001);
    rd(8'h0C, 32'h4000_1234, "R4 status equal threshold");
    wr(8'h08, 32'h0);
    check(32'(fifo_level), 32'h40, "R3 run=0 holds level");
    wr(8'h0C, 32'hFFFF_FFFF);
    xfer_count = 14'h3FFF;
    rd(8'h0C, 32'h4000_3FFF, "R8 status write ignored");
    wr(8'h00, 32'h0000_3000);
    wr(8'h08, 32'h1);
    check(32'(fifo_level), 0, "R3 start empty");
    rd(8'h0C, 32'h0000_3FFF, "R4 status empty");
    // R5 clear pulse
    wr_clr(8'h14, 32'h0000_0105, 1'b1, "R5 clear with bit8");
    check(32'(ecc_ptr), 5, "R6 ptr 5 stored");
    wr_clr(8'h14, 32'h0000_0006, 1'b0, "R5 no clear without bit8");
    wr_clr(8'h10, 32'h0000_0100, 1'b0, "R5 no clear other reg");
    // R6 pointer validity
    wr(8'h10, 32'hF);
    wr(8'h14, 32'h9);
    check(32'(ecc_ptr), 9, "R6 ptr 9 valid");
    check(32'(ecc_enable), 1, "R6 enable kept");
    wr(8'h14, 32'hA);
    check(32'(ecc_ptr), 0, "R6 ptr 10 invalid");
    check(32'(ecc_enable), 0, "R6 enable cleared");
    rd(8'h10, 32'hE, "R6 cfg upper bits kept");
    wr(8'h10, 32'h1);
    wr(8'h14, 32'h0);
    check(32'({ecc_ptr, ecc_enable}), 0, "R6 ptr 0 invalid");
    wr(8'h10, 32'h1);
    wr(8'h14, 32'h1);
    check(32'({ecc_ptr, ecc_enable}), 32'h3, "R6 ptr 1 valid");
    // R7/R8 results
    for (int s = 0; s < 8; s++) rd(8'(8'h40 + 4 * s), pack_word(s), $sformatf("R7 slot %0d", s));
    rd(8'h60, pack_word(0), "R8 0x60 aliases slot 0");
    wr(8'h44, 32'hFFFF_FFFF);
    rd(8'h44, pack_word(1), "R8 result write ignored");
    repeat (3) @(negedge clk);
    check(32'(exp_q.size()), 0, "scoreboard drained");
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule